// File: doc/BRIEF.md
# Reed-Solomon NAND Parity Encoder

This block protects one flash sector on its way to the NAND interface. It accepts the sector as a stream of bytes and regroups the bit stream into 9-bit symbols over GF(2^9). In protected mode it divides the symbol sequence by a degree-10 generator polynomial in a systematic LFSR. After the last data symbol it emits the 10 remainder symbols, so the sector becomes a shortened codeword with minimum distance 11.

With the default geometry, a sector holds 512 payload bytes and 4 wear-levelling bytes, which is 4128 bits. Three zero bits are prepended to fill 459 data symbols, and the full codeword is 469 symbols. A pulse on `sector_start_i` arms the block and latches the protection enable. When protection is off, the same symbol stream passes through unchanged and no parity follows it.

The control path is a three-state machine:
- `ST_IDLE` waits for a start pulse.
- `ST_DATA` accepts bytes and forwards symbols.
- `ST_PARITY` shifts out the remainder.

It has these transitions:
- IDLE→DATA on a start pulse.
- DATA→PARITY on the final data symbol when protection is on.
- DATA→IDLE on the final data symbol when protection is off.
- PARITY→IDLE on the final parity symbol.

Top module: `rs_nand_parity_enc`

## Requirements
- R1: After reset the block is in `ST_IDLE`, with `in_ready_o` and `out_valid_o` low.
- R2: A start pulse in `ST_IDLE` opens a sector. `in_ready_o` is high in `ST_DATA` until exactly SECTOR_BYTES bytes have been accepted (valid and ready on one edge), and low in `ST_IDLE`. A start pulse while a sector is in progress is ignored and leaves the output stream unaffected.
- R3: Symbols come from the byte stream taken MSB first. PAD zero bits (3 by default) are placed ahead of the first byte, so the first symbol is those zeros followed by the top 6 bits of byte 0. Each 9-bit symbol is sent MSB first, and a data symbol appears on the output the cycle after the byte that completes it is accepted.
- R4: In protected mode, exactly 10 parity symbols follow the data symbols on consecutive cycles, highest degree first. The field is built on x^9+x^4+1 with alpha=2. The whole codeword c, read in output order as coefficients from highest degree down, satisfies c(alpha^j)=0 for j=0..9.
- R5: `out_last_o` is high on exactly one symbol per sector: the final parity symbol when protected, the final data symbol in bypass. The cycle after it, `out_valid_o` is low.
- R6: `out_parity_o` is high exactly on parity symbols.
- R7: `in_ready_o` is low on every cycle that a parity symbol is emitted.
- R8: The protection enable is sampled only at the start pulse. In bypass mode the 459 data symbols are emitted unchanged and no parity is emitted.
- R9: The remainder register is cleared at every sector start, so each sector's parity depends only on that sector's data.
- R10: A sector of all-zero bytes yields 10 zero parity symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sector_start_i | input | 1 | Start-of-sector pulse, honoured in idle only |
| protect_en_i | input | 1 | 1 = append parity, 0 = bypass; sampled at start |
| in_valid_i | input | 1 | Byte valid |
| in_byte_i | input | 8 | Sector byte |
| in_ready_o | output | 1 | Byte accepted when high together with valid |
| out_valid_o | output | 1 | Output symbol valid |
| out_sym_o | output | 9 | Data or parity symbol |
| out_parity_o | output | 1 | Current symbol is parity |
| out_last_o | output | 1 | Final symbol of the sector |

## Verification
The bench builds the block with its default parameters: 516-byte sectors and 10 parity symbols. This gives 459 data symbols and a 3-bit zero pad, so the full-length 469-symbol codeword and the odd pad alignment at the head of the stream are both exercised. Throttled input and back-to-back sectors are driven in both modes. Parity is judged by evaluating the received codeword at the ten generator roots, so any fault in the field polynomial, the taps or the output order shows up as a nonzero result.

// File: rtl/rsenc_pkg.sv
package rsenc_pkg;

    localparam int GF_W = 9;
    localparam logic [GF_W:0] GF_POLY = 10'h211;   // x^9 + x^4 + 1
    localparam int MAX_PAR = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_PARITY = 2'd2
    } enc_state_e;

    // Product of two field elements: shift-and-add with reduction.
    function automatic logic [GF_W-1:0] gf_mul(input logic [GF_W-1:0] a,
                                               input logic [GF_W-1:0] b);
        logic [GF_W-1:0] acc;
        logic [GF_W-1:0] run;
        acc = '0;
        run = a;
        for (int k = 0; k < GF_W; k++) begin
            if (b[k]) acc = acc ^ run;
            if (run[GF_W-1]) run = (run << 1) ^ GF_POLY[GF_W-1:0];
            else             run = run << 1;
        end
        return acc;
    endfunction

    // Coefficient idx of prod_{r=0}^{npar-1} (x + alpha^r).
    function automatic logic [GF_W-1:0] gen_coeff(input int idx, input int npar);
        logic [GF_W-1:0] g [0:MAX_PAR];
        logic [GF_W-1:0] root;
        for (int k = 0; k <= MAX_PAR; k++) g[k] = '0;
        g[0] = GF_W'(1);
        root = GF_W'(1);
        for (int r = 0; r < MAX_PAR; r++) begin
            if (r < npar) begin
                for (int k = MAX_PAR; k >= 1; k--) g[k] = g[k-1] ^ gf_mul(g[k], root);
                g[0] = gf_mul(g[0], root);
                root = gf_mul(root, GF_W'(2));
            end
        end
        return g[idx];
    endfunction

endpackage

// File: rtl/rsenc_packer.sv
module rsenc_packer #(
    parameter int SYM_W = 9,
    parameter int PAD   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             take_i,
    input  logic [7:0]       byte_i,
    output logic             sym_v_o,
    output logic [SYM_W-1:0] sym_o
);
    localparam int HOLD_W = SYM_W - 1;
    localparam int WIDE_W = HOLD_W + 8;
    localparam int CNT_W  = $clog2(WIDE_W + 1);
    localparam logic [CNT_W-1:0] SYM_C = CNT_W'(SYM_W);
    localparam logic [CNT_W-1:0] PAD_C = CNT_W'(PAD);
    localparam logic [CNT_W-1:0] BYTE_C = CNT_W'(8);

    logic [HOLD_W-1:0] hold_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WIDE_W-1:0] wide;
    logic [CNT_W-1:0]  cnt_wide;
    logic              emit;
    logic [WIDE_W-1:0] shifted;

    always_comb begin
        wide     = {hold_q, byte_i};
        cnt_wide = cnt_q + BYTE_C;
        emit     = (cnt_wide >= SYM_C);
        shifted  = wide >> (cnt_wide - SYM_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            cnt_q   <= PAD_C;
            sym_v_o <= 1'b0;
            sym_o   <= '0;
        end else begin
            sym_v_o <= 1'b0;
            if (clr_i) begin
                hold_q <= '0;
                cnt_q  <= PAD_C;
            end else if (take_i) begin
                hold_q <= wide[HOLD_W-1:0];
                if (emit) begin
                    cnt_q   <= cnt_wide - SYM_C;
                    sym_v_o <= 1'b1;
                    sym_o   <= shifted[SYM_W-1:0];
                end else begin
                    cnt_q <= cnt_wide;
                end
            end
        end
    end
endmodule

// File: rtl/rsenc_lfsr.sv
module rsenc_lfsr #(
    parameter int SYM_W = 9,
    parameter int NPAR  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             feed_i,
    input  logic             shift_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic [SYM_W-1:0] top_o
);
    logic [NPAR-1:0][SYM_W-1:0] rem_q;
    logic [NPAR-1:0][SYM_W-1:0] rem_fed;
    logic [SYM_W-1:0]           fb;

    assign fb    = sym_i ^ rem_q[NPAR-1];
    assign top_o = rem_q[NPAR-1];

    for (genvar i = 0; i < NPAR; i++) begin : g_tap
        localparam logic [SYM_W-1:0] COEF = rsenc_pkg::gen_coeff(i, NPAR);
        if (i == 0) begin : g_low
            assign rem_fed[i] = rsenc_pkg::gf_mul(fb, COEF);
        end else begin : g_up
            assign rem_fed[i] = rem_q[i-1] ^ rsenc_pkg::gf_mul(fb, COEF);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rem_q <= '0;
        else if (clr_i)    rem_q <= '0;
        else if (feed_i)   rem_q <= rem_fed;
        else if (shift_i)  rem_q <= {rem_q[NPAR-2:0], {SYM_W{1'b0}}};
    end
endmodule

// File: rtl/rs_nand_parity_enc.sv
module rs_nand_parity_enc #(
    parameter int SECTOR_BYTES = 516,
    parameter int NPAR         = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sector_start_i,
    input  logic       protect_en_i,
    input  logic       in_valid_i,
    input  logic [7:0] in_byte_i,
    output logic       in_ready_o,
    output logic       out_valid_o,
    output logic [8:0] out_sym_o,
    output logic       out_parity_o,
    output logic       out_last_o
);
    import rsenc_pkg::*;

    localparam int SYM_W     = GF_W;
    localparam int DATA_BITS = 8 * SECTOR_BYTES;
    localparam int NSYM      = (DATA_BITS + SYM_W - 1) / SYM_W;
    localparam int PAD       = NSYM * SYM_W - DATA_BITS;
    localparam int BCNT_W    = $clog2(SECTOR_BYTES + 1);
    localparam int SCNT_W    = $clog2(NSYM + 1);
    localparam int PCNT_W    = $clog2(NPAR + 1);
    localparam logic [BCNT_W-1:0] BYTES_C    = BCNT_W'(SECTOR_BYTES);
    localparam logic [SCNT_W-1:0] LAST_SYM_C = SCNT_W'(NSYM - 1);
    localparam logic [PCNT_W-1:0] LAST_PAR_C = PCNT_W'(NPAR - 1);

    enc_state_e        state_q, state_d;
    logic              prot_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic [SCNT_W-1:0] scnt_q;
    logic [PCNT_W-1:0] pcnt_q;

    logic              start_ok;
    logic              accept;
    logic              pk_v;
    logic [SYM_W-1:0]  pk_sym;
    logic [SYM_W-1:0]  par_top;
    logic              last_data;
    logic              last_par;

    assign start_ok  = (state_q == ST_IDLE) && sector_start_i;
    assign accept    = in_valid_i && in_ready_o;
    assign last_data = (state_q == ST_DATA) && pk_v && (scnt_q == LAST_SYM_C);
    assign last_par  = (state_q == ST_PARITY) && (pcnt_q == LAST_PAR_C);

    rsenc_packer #(
        .SYM_W (SYM_W),
        .PAD   (PAD)
    ) i_packer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_ok),
        .take_i  (accept),
        .byte_i  (in_byte_i),
        .sym_v_o (pk_v),
        .sym_o   (pk_sym)
    );

    rsenc_lfsr #(
        .SYM_W (SYM_W),
        .NPAR  (NPAR)
    ) i_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_ok),
        .feed_i  ((state_q == ST_DATA) && pk_v && prot_q),
        .shift_i (state_q == ST_PARITY),
        .sym_i   (pk_sym),
        .top_o   (par_top)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sector_start_i) state_d = ST_DATA;
            ST_DATA:   if (last_data) state_d = prot_q ? ST_PARITY : ST_IDLE;
            ST_PARITY: if (last_par) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and sector counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prot_q  <= 1'b0;
            bcnt_q  <= '0;
            scnt_q  <= '0;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                prot_q <= protect_en_i;
                bcnt_q <= '0;
                scnt_q <= '0;
                pcnt_q <= '0;
            end else begin
                if (accept) bcnt_q <= bcnt_q + 1'b1;
                if ((state_q == ST_DATA) && pk_v) scnt_q <= scnt_q + 1'b1;
                if (state_q == ST_PARITY) pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready_o   = 1'b0;
        out_valid_o  = 1'b0;
        out_sym_o    = '0;
        out_parity_o = 1'b0;
        out_last_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DATA: begin
                in_ready_o  = (bcnt_q < BYTES_C);
                out_valid_o = pk_v;
                out_sym_o   = pk_sym;
                out_last_o  = last_data && !prot_q;
            end
            ST_PARITY: begin
                out_valid_o  = 1'b1;
                out_sym_o    = par_top;
                out_parity_o = 1'b1;
                out_last_o   = last_par;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rsenc_checker.sv
module rsenc_checker #(
    parameter int SECTOR_BYTES = 516,
    parameter int NPAR         = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid_i,
    input logic       in_ready_o,
    input logic       out_valid_o,
    input logic       out_parity_o,
    input logic       out_last_o
);
    localparam int AW = $clog2(SECTOR_BYTES + 2);
    localparam int PW = $clog2(NPAR + 2);
    localparam logic [AW-1:0] BYTES_C = AW'(SECTOR_BYTES);
    localparam logic [PW-1:0] RUN_C   = PW'(NPAR - 1);

    logic [AW-1:0] took_q;
    logic [PW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            took_q <= '0;
            run_q  <= '0;
        end else begin
            if (out_valid_o && out_last_o)     took_q <= '0;
            else if (in_valid_i && in_ready_o) took_q <= took_q + 1'b1;
            if (out_parity_o) run_q <= run_q + 1'b1;
            else              run_q <= '0;
        end
    end

    p_byte_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        took_q <= BYTES_C);

    p_sym_after_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_parity_o) |-> $past(in_valid_i && in_ready_o));

    p_parity_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_parity_o && !out_last_o) |=> out_parity_o);

    p_parity_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_parity_o && out_last_o) |-> (run_q == RUN_C));

    p_last_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |=> !out_valid_o);

    p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);

    p_parity_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_parity_o |-> out_valid_o);

    p_no_take_in_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_parity_o |-> !in_ready_o);
endmodule

bind rs_nand_parity_enc rsenc_checker #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .NPAR         (NPAR)
) i_rsenc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .out_valid_o  (out_valid_o),
    .out_parity_o (out_parity_o),
    .out_last_o   (out_last_o)
);

// File: tb/test_rs_nand_parity_enc.sv
`timescale 1ns/100ps
module test_rs_nand_parity_enc;
    localparam int SB   = 516;
    localparam int NP   = 10;
    localparam int NS   = 459;
    localparam int PADB = 3;
    localparam int MAXO = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sector_start = 1'b0;
    logic       protect_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_ready, out_valid, out_parity, out_last;
    logic [8:0] out_sym;

    int total = 0;
    int bad = 0;

    logic [7:0] sect [SB];
    logic [8:0] got  [MAXO];
    logic       gl   [MAXO];
    logic       gp   [MAXO];
    int  got_n = 0;
    int  last_at = -1;
    int  r7_viol = 0;
    bit  mon_en = 1'b0;

    always #2.5 clk = ~clk;

    rs_nand_parity_enc i_rs_nand_parity_enc (
        .clk            (clk),
        .rst_n          (rst_n),
        .sector_start_i (sector_start),
        .protect_en_i   (protect_en),
        .in_valid_i     (in_valid),
        .in_byte_i      (in_byte),
        .in_ready_o     (in_ready),
        .out_valid_o    (out_valid),
        .out_sym_o      (out_sym),
        .out_parity_o   (out_parity),
        .out_last_o     (out_last)
    );

    always @(negedge clk) begin
        if (mon_en && out_valid) begin
            if (got_n < MAXO) begin
                got[got_n] = out_sym;
                gl[got_n]  = out_last;
                gp[got_n]  = out_parity;
            end
            if (out_last) last_at = got_n;
            got_n++;
        end
        if (mon_en && out_parity && in_ready) r7_viol++;
    end

    function automatic logic [8:0] gmul(input logic [8:0] a, input logic [8:0] b);
        logic [17:0] p = '0;
        for (int k = 0; k < 9; k++) if (b[k]) p = p ^ (18'(a) << k);
        for (int k = 17; k >= 9; k--) if (p[k]) p = p ^ (18'h211 << (k - 9));
        return p[8:0];
    endfunction

    function automatic logic [8:0] exp_sym(input int s);
        logic [8:0] v = '0;
        for (int b = 0; b < 9; b++) begin
            int k = 9 * s + b;
            logic bitv;
            if (k < PADB) bitv = 1'b0;
            else bitv = sect[(k - PADB) / 8][7 - ((k - PADB) % 8)];
            v = {v[7:0], bitv};
        end
        return v;
    endfunction

    function automatic logic [8:0] syndrome(input int j, input int n);
        logic [8:0] a = 9'd1;
        logic [8:0] s = '0;
        for (int t = 0; t < j; t++) a = gmul(a, 9'd2);
        for (int k = 0; k < n; k++) s = gmul(s, a) ^ got[k];
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int mode);
        for (int i = 0; i < SB; i++) begin
            case (mode)
                0: sect[i] = 8'((i * 7 + 3) & 8'hFF);
                1: sect[i] = 8'hFF;
                2: sect[i] = 8'h00;
                default: sect[i] = 8'((i * 37) ^ (i >> 3) ^ 8'h5A);
            endcase
        end
    endtask

    task automatic run_sector(input bit prot, input int gap, input bit mid_sos);
        int i = 0;
        int c = 0;
        got_n = 0; last_at = -1; r7_viol = 0; mon_en = 1'b1;
        @(negedge clk); sector_start = 1'b1; protect_en = prot;
        @(negedge clk); sector_start = 1'b0; protect_en = !prot;
        while (i < SB) begin
            @(negedge clk);
            c++;
            sector_start = mid_sos && (i == 200);
            in_valid = !(gap > 0 && (c % gap) == 0);
            in_byte = sect[i];
            if (in_valid && in_ready) i++;
        end
        @(negedge clk); in_valid = 1'b0; sector_start = 1'b0;
        chk(in_ready == 1'b0, "R2", "ready after full sector", int'(in_ready), 0);
        for (int w = 0; w < 60 && last_at < 0; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        mon_en = 1'b0;
    endtask

    task automatic check_sector(input bit prot, input string tag);
        int n_exp = prot ? NS + NP : NS;
        int mism = 0, first_bad = 0, nlast = 0, flag_bad = 0;
        chk(got_n == n_exp, prot ? "R4" : "R8", {tag, " symbol count"}, got_n, n_exp);
        for (int s = 0; s < NS && s < got_n; s++) begin
            if (got[s] !== exp_sym(s)) begin
                if (mism == 0) first_bad = s;
                mism++;
            end
        end
        chk(mism == 0, "R3", {tag, " data symbols (count of mismatches)"}, mism, 0);
        if (mism != 0) chk(1'b0, "R3", {tag, " first bad symbol"}, got[first_bad], exp_sym(first_bad));
        for (int k = 0; k < got_n && k < MAXO; k++) begin
            if (gl[k]) nlast++;
            if (gp[k] !== (k >= NS)) flag_bad++;
        end
        chk(nlast == 1 && last_at == n_exp - 1, "R5", {tag, " last position"}, last_at, n_exp - 1);
        chk(flag_bad == 0, prot ? "R6" : "R8", {tag, " parity flags"}, flag_bad, 0);
        chk(r7_viol == 0, "R7", {tag, " ready during parity"}, r7_viol, 0);
        if (prot && got_n == n_exp) begin
            for (int j = 0; j < NP; j++)
                chk(syndrome(j, n_exp) == 9'd0, "R4", {tag, " codeword root"}, syndrome(j, n_exp), 0);
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b0, "R1", "ready after reset", int'(in_ready), 0);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R2", "idle ignores bytes",
            int'({in_ready, out_valid}), 0);
        in_valid = 1'b0;
    endtask

    task automatic t_ramp();
        fill(0); run_sector(1'b1, 0, 1'b0); check_sector(1'b1, "ramp");
    endtask

    task automatic t_ones();
        fill(1); run_sector(1'b1, 0, 1'b0); check_sector(1'b1, "ones");
        chk(got[0] == 9'h03F, "R3", "leading pad bits", got[0], 9'h03F);
    endtask

    task automatic t_zero();
        int nz = 0;
        fill(2); run_sector(1'b1, 0, 1'b0); check_sector(1'b1, "zero");
        for (int k = NS; k < NS + NP; k++) if (got[k] != 9'd0) nz++;
        chk(nz == 0, "R10", "zero sector parity", nz, 0);
    endtask

    task automatic t_bypass();
        fill(3); run_sector(1'b0, 0, 1'b0); check_sector(1'b0, "bypass R8");
    endtask

    task automatic t_throttle();
        fill(3); run_sector(1'b1, 3, 1'b0); check_sector(1'b1, "throttled");
    endtask

    task automatic t_mid_start();
        fill(0); run_sector(1'b1, 0, 1'b1); check_sector(1'b1, "mid-start R2");
    endtask

    task automatic t_back_to_back();
        fill(1); run_sector(1'b1, 0, 1'b0);
        fill(3); run_sector(1'b1, 0, 1'b0); check_sector(1'b1, "second sector R9");
    endtask

    initial begin
        #(5.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ramp();
        t_ones();
        t_zero();
        t_bypass();
        t_throttle();
        t_mid_start();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule